// File: doc/BRIEF.md
# Block-Lock Write Guard

This block keeps the protection state of a small serial nonvolatile byte array: a write-protect enable bit, a two-bit block-lock code and the write enable latch. For every array byte that a write sequence would program, it gives a permit. It also gives a permit for a status register write, and it reports the status byte that a status read returns. The serial decoder in front of it supplies one-cycle strobes: set-enable, clear-enable, a status data byte with a valid pulse, and a write-completion pulse. It also supplies a level that marks the chip select as active, the address of the array byte being written, and a busy level from the write timer.

There are two independent sources of protection. The block-lock code fences off the top quarter, the top half or the whole array. No other input can open those addresses. A hardware lock is active when the write-protect pin is low and the enable bit is set. While it is active, the status register is frozen, and the enable bit cannot be cleared. A status write is held pending while the select is active. It takes effect on the cycle the select drops. If the hardware lock comes on before that cycle, the pending write is dropped.

Top module: `blocklock_guard`

## Requirements
- R1: After reset the status byte equals {INIT_WPEN, 3'b000, INIT_BP, 1'b0, 1'b0}. With the defaults this is 8'h00.
- R2: The status byte is formed as follows: bit 7 is the protect-enable bit, bits 6..4 read 0, bits 3..2 are the block-lock code, bit 1 is the write enable latch and bit 0 is the busy level.
- R3: A set-enable strobe sets the latch one cycle later. A clear-enable strobe or a completion pulse clears it. When a clear and a set arrive in the same cycle, the clear wins.
- R4: With the address in 11 bits, the array permit is 0 inside the locked range, whatever the state of the pin and the enable bit. Code 00 locks nothing. Code 01 locks 0x600..0x7FF, code 10 locks 0x400..0x7FF and code 11 locks 0x000..0x7FF.
- R5: While the latch is 0, both permits are 0, and a status write is not captured.
- R6: The status permit equals latch AND NOT(pin low AND enable bit 1). The array permit for an unlocked address equals the latch.
- R7: A status data byte that arrives with the select active, the latch set and no hardware lock becomes pending. It is applied on the first cycle the select is inactive. That cycle raises the commit output, and only data bits 7, 3 and 2 are stored.
- R8: A pending status write is dropped if the hardware lock is active while the select is still active. A pin change on the commit cycle does not stop the commit.
- R9: While the busy level is 1, the status byte reads 8'hFF.
- R10: While the pin is low and the enable bit is 1, a status write cannot clear the enable bit or change the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_pin | input | 1 | Write-protect pin level (0 = asserted low) |
| wren_stb | input | 1 | Set-enable strobe |
| wrdi_stb | input | 1 | Clear-enable strobe |
| srw_vld | input | 1 | Status data byte valid |
| srw_data | input | 8 | Status data byte |
| wr_done | input | 1 | Write cycle completion pulse |
| cs_act | input | 1 | Chip select active |
| nv_busy | input | 1 | Write cycle running |
| arr_addr | input | ADDR_W | Target address of the array byte |
| status_byte | output | 8 | Status read-back byte |
| arr_ok | output | 1 | Array byte write permitted |
| sr_ok | output | 1 | Status register write permitted |
| sr_commit | output | 1 | Pending status write applied this cycle |

## Verification
The array permit is tested at the addresses on either side of each lock boundary, for all four codes. A wrong boundary or a wrong code mapping therefore shows up as a permit on the wrong side of the boundary. Status writes are tried in four ways: with the latch clear, with reserved bits set, under the hardware lock, and with the pin dropped either before or on the cycle the select is released. These cases separate a capture gate that is wrong from a cancel that comes too late or too early. The latch is tested with a set and a clear in the same cycle, and with a set and a completion pulse in the same cycle, so that the priority between set and clear is visible.

// File: rtl/blk_pkg.sv
package blk_pkg;
  localparam int STAT_W = 8;
  typedef logic [1:0] bp_code_t;
  localparam bp_code_t BP_NONE = 2'b00;
  localparam bp_code_t BP_QUAR = 2'b01;
  localparam bp_code_t BP_HALF = 2'b10;
  localparam bp_code_t BP_FULL = 2'b11;
endpackage

// File: rtl/blk_zone_map.sv
module blk_zone_map
  import blk_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  bp_code_t          code,
  output logic              locked
);
  localparam int TOP = ADDR_W - 1;
  localparam int NXT = ADDR_W - 2;

  always_comb begin
    unique case (code)
      BP_NONE: locked = 1'b0;
      BP_QUAR: locked = addr[TOP] & addr[NXT];
      BP_HALF: locked = addr[TOP];
      default: locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/blk_wel.sv
module blk_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_stb,
  input  logic clr_stb,
  input  logic done_stb,
  output logic wel
);
  logic wel_d;

  always_comb begin
    wel_d = wel;
    if (set_stb) wel_d = 1'b1;
    if (clr_stb || done_stb) wel_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wel <= 1'b0;
    else        wel <= wel_d;
  end

  AST_WEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb && !clr_stb && !done_stb) |=> wel); // R3
  AST_WEL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb || done_stb) |=> !wel); // R3
endmodule

// File: rtl/blk_status_regs.sv
module blk_status_regs
  import blk_pkg::*;
#(
  parameter logic     INIT_WPEN = 1'b0,
  parameter bp_code_t INIT_BP   = BP_NONE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wp_pin,
  input  logic        wel,
  input  logic        cs_act,
  input  logic        srw_vld,
  input  logic [STAT_W-1:0] srw_data,
  output logic        wpen,
  output bp_code_t    bp,
  output logic        hwlock,
  output logic        commit
);
  logic     pend_q, pend_d;
  logic     pwpen_q, pwpen_d;
  bp_code_t pbp_q, pbp_d;
  logic     wpen_d;
  bp_code_t bp_d;
  logic     capture;

  assign hwlock  = ~wp_pin & wpen;
  assign commit  = pend_q & ~cs_act;
  assign capture = srw_vld & cs_act & wel & ~hwlock;

  always_comb begin
    pend_d  = pend_q;
    pwpen_d = pwpen_q;
    pbp_d   = pbp_q;
    wpen_d  = wpen;
    bp_d    = bp;
    if (commit) begin
      pend_d = 1'b0;
      wpen_d = pwpen_q;
      bp_d   = pbp_q;
    end else if (pend_q && hwlock) begin
      pend_d = 1'b0;
    end
    if (capture) begin
      pend_d  = 1'b1;
      pwpen_d = srw_data[7];
      pbp_d   = srw_data[3:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      pwpen_q <= 1'b0;
      pbp_q   <= BP_NONE;
      wpen    <= INIT_WPEN;
      bp      <= INIT_BP;
    end else begin
      pend_q  <= pend_d;
      pwpen_q <= pwpen_d;
      pbp_q   <= pbp_d;
      wpen    <= wpen_d;
      bp      <= bp_d;
    end
  end

  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (hwlock && !pend_q) |=> ($stable(wpen) && $stable(bp))); // R10
  AST_CANCEL_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && cs_act && hwlock) |=> !pend_q); // R8
  AST_NO_CAPTURE_UNLATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !wel) |=> !pend_q); // R5
endmodule

// File: rtl/blocklock_guard.sv
module blocklock_guard
  import blk_pkg::*;
#(
  parameter int       ADDR_W    = 11,
  parameter logic     INIT_WPEN = 1'b0,
  parameter bp_code_t INIT_BP   = BP_NONE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_pin,
  input  logic              wren_stb,
  input  logic              wrdi_stb,
  input  logic              srw_vld,
  input  logic [7:0]        srw_data,
  input  logic              wr_done,
  input  logic              cs_act,
  input  logic              nv_busy,
  input  logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        status_byte,
  output logic              arr_ok,
  output logic              sr_ok,
  output logic              sr_commit
);
  logic     wel, wpen, hwlock, locked;
  bp_code_t bp;

  blk_wel u_wel (
    .clk(clk), .rst_n(rst_n), .set_stb(wren_stb), .clr_stb(wrdi_stb),
    .done_stb(wr_done), .wel(wel)
  );

  blk_status_regs #(.INIT_WPEN(INIT_WPEN), .INIT_BP(INIT_BP)) u_sr (
    .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin), .wel(wel), .cs_act(cs_act),
    .srw_vld(srw_vld), .srw_data(srw_data), .wpen(wpen), .bp(bp),
    .hwlock(hwlock), .commit(sr_commit)
  );

  blk_zone_map #(.ADDR_W(ADDR_W)) u_zone (
    .addr(arr_addr), .code(bp), .locked(locked)
  );

  assign arr_ok = wel & ~locked;
  assign sr_ok  = wel & ~hwlock;

  always_comb begin
    if (nv_busy) status_byte = 8'hFF;
    else         status_byte = {wpen, 3'b000, bp, wel, 1'b0};
  end

  AST_FULL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[3:2] == BP_FULL && !nv_busy) |-> !arr_ok); // R4
  AST_NO_PERMIT_UNLATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_done) |-> (!arr_ok && !sr_ok)); // R5
endmodule

// File: tb/sim_blocklock_guard.sv
module sim_blocklock_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_pin = 1'b1, wren_stb = 1'b0, wrdi_stb = 1'b0, srw_vld = 1'b0;
  logic [7:0] srw_data = 8'h00;
  logic wr_done = 1'b0, cs_act = 1'b0, nv_busy = 1'b0;
  logic [10:0] arr_addr = 11'h000;
  logic [7:0] status_byte;
  logic arr_ok, sr_ok, sr_commit;
  int errors = 0, checks = 0;
  logic saw_commit;

  always #2.5 clk = ~clk;

  blocklock_guard u0 (
    .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin), .wren_stb(wren_stb),
    .wrdi_stb(wrdi_stb), .srw_vld(srw_vld), .srw_data(srw_data),
    .wr_done(wr_done), .cs_act(cs_act), .nv_busy(nv_busy),
    .arr_addr(arr_addr), .status_byte(status_byte), .arr_ok(arr_ok),
    .sr_ok(sr_ok), .sr_commit(sr_commit)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic strobe_wren;
    wren_stb = 1'b1; step; wren_stb = 1'b0; step;
  endtask

  // status write: byte with select active, select release, completion pulse
  task automatic do_wrsr(input logic [7:0] d, input logic drop_wp_at_release);
    cs_act = 1'b1; srw_vld = 1'b1; srw_data = d; step;
    srw_vld = 1'b0; step;
    cs_act = 1'b0;
    if (drop_wp_at_release) wp_pin = 1'b0;
    #1 saw_commit = sr_commit;
    step;
    wr_done = 1'b1; step; wr_done = 1'b0; step;
  endtask

  task automatic t_reset;
    chk("R1 reset status", status_byte, 8'h00);
    chk("R5 reset arr_ok", {7'd0, arr_ok}, 8'h00);
    chk("R5 reset sr_ok", {7'd0, sr_ok}, 8'h00);
  endtask

  task automatic t_wel;
    wren_stb = 1'b1; step; wren_stb = 1'b0;
    chk("R3 set latch / R2 bit1", status_byte, 8'h02);
    wrdi_stb = 1'b1; step; wrdi_stb = 1'b0;
    chk("R3 clear latch", status_byte, 8'h00);
    wren_stb = 1'b1; wrdi_stb = 1'b1; step; wren_stb = 1'b0; wrdi_stb = 1'b0;
    chk("R3 clear beats set", status_byte, 8'h00);
    wren_stb = 1'b1; wr_done = 1'b1; step; wren_stb = 1'b0; wr_done = 1'b0;
    chk("R3 done beats set", status_byte, 8'h00);
    strobe_wren; wr_done = 1'b1; step; wr_done = 1'b0;
    chk("R3 done clears latch", status_byte, 8'h00);
  endtask

  task automatic t_nowel;
    do_wrsr(8'h0C, 1'b0);
    chk("R5 no commit unlatched", {7'd0, saw_commit}, 8'h00);
    chk("R5 status unchanged", status_byte, 8'h00);
    arr_addr = 11'h000;
    chk("R5 arr_ok unlatched", {7'd0, arr_ok}, 8'h00);
  endtask

  task automatic map_probe(input logic [1:0] code, input logic [10:0] a_ok, input logic [10:0] a_lk);
    strobe_wren; do_wrsr({4'h0, code, 2'b00}, 1'b0);
    chk("R7 commit seen", {7'd0, saw_commit}, 8'h01);
    chk("R2 code field", status_byte, {4'h0, code, 2'b00});
    strobe_wren;
    arr_addr = a_ok; #1;
    chk("R4 open side", {7'd0, arr_ok}, {7'd0, code != 2'b11});
    arr_addr = a_lk; #1;
    chk("R4 locked side", {7'd0, arr_ok}, {7'd0, code == 2'b00});
    wrdi_stb = 1'b1; step; wrdi_stb = 1'b0;
  endtask

  task automatic t_map;
    map_probe(2'b01, 11'h5FF, 11'h600);
    map_probe(2'b10, 11'h3FF, 11'h400);
    map_probe(2'b11, 11'h7FF, 11'h000);
    map_probe(2'b00, 11'h000, 11'h7FF);
  endtask

  task automatic t_rsvd;
    strobe_wren; do_wrsr(8'h73, 1'b0);
    chk("R7 reserved bits dropped", status_byte, 8'h00);
    strobe_wren; do_wrsr(8'hFF, 1'b0);
    chk("R7 only bits 7,3,2 kept", status_byte, 8'h8C);
    strobe_wren; do_wrsr(8'h00, 1'b0);
    chk("R7 clear back", status_byte, 8'h00);
  endtask

  task automatic t_lock;
    strobe_wren; do_wrsr(8'h80, 1'b0);
    chk("R7 enable bit set", status_byte, 8'h80);
    wp_pin = 1'b0; strobe_wren;
    chk("R6 sr_ok locked", {7'd0, sr_ok}, 8'h00);
    arr_addr = 11'h7FF; #1;
    chk("R6 array open under lock", {7'd0, arr_ok}, 8'h01);
    do_wrsr(8'h0C, 1'b0);
    chk("R10 no commit under lock", {7'd0, saw_commit}, 8'h00);
    chk("R10 enable bit held", status_byte, 8'h80);
    wp_pin = 1'b1; strobe_wren;
    chk("R6 sr_ok pin high", {7'd0, sr_ok}, 8'h01);
    wrdi_stb = 1'b1; step; wrdi_stb = 1'b0;
  endtask

  task automatic t_cancel;
    strobe_wren;
    cs_act = 1'b1; srw_vld = 1'b1; srw_data = 8'h0C; step;
    srw_vld = 1'b0; wp_pin = 1'b0; step;
    cs_act = 1'b0; #1 saw_commit = sr_commit; step;
    chk("R8 cancelled, no commit", {7'd0, saw_commit}, 8'h00);
    chk("R8 status unchanged", status_byte, 8'h82);
    wp_pin = 1'b1; wrdi_stb = 1'b1; step; wrdi_stb = 1'b0;
    strobe_wren; do_wrsr(8'h8C, 1'b1);
    chk("R8 commit despite pin drop at release", {7'd0, saw_commit}, 8'h01);
    chk("R8 value applied", status_byte, 8'h8C);
    wp_pin = 1'b1; strobe_wren; do_wrsr(8'h00, 1'b0);
    chk("R7 restore", status_byte, 8'h00);
  endtask

  task automatic t_busy;
    nv_busy = 1'b1; #1;
    chk("R9 busy reads FF", status_byte, 8'hFF);
    nv_busy = 1'b0; #1;
    chk("R9 busy released", status_byte, 8'h00);
  endtask

  initial begin
    repeat (3) step;
    rst_n = 1'b1;
    step;
    t_reset;
    t_wel;
    t_nowel;
    t_map;
    t_rsvd;
    t_lock;
    t_cancel;
    t_busy;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule